// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

A synchronous SRAM front end built around a word-organised memory with four byte lanes. All control, address and write data are captured on the rising clock edge. Read data leaves through an output register one clock after the address was taken. Two address strobes can open an access. The processor strobe is gated by the first chip select, wins over the other strobe, and always opens a read. The controller strobe can open either a read or a one-clock write. After an access is open, cycles with both strobes high continue the burst. They either advance the low two address bits or hold the current address, and they read or write depending on the write inputs.

The data bus is modelled as separate input, output and drive-enable signals. The drive enable is the output-register valid flag gated by the asynchronous output enable. It is forced low in several cases: during writes, on a deselect, on the first cycle of an access that opens from the deselected state, and in sleep. A sleep input passes through a two-stage synchroniser. While the synchronised sleep level is high, no access takes place and the memory contents are kept.

Top module: `sram_burst_ctrl`

## Requirements
- R1: An access opens at a clock edge when an address strobe counts and the chip selects are all active (cs1_ni low, cs2_i high, cs3_ni low). If a counting strobe is low and the chip selects are not all active, the cycle is a deselect and closes the access.
- R2: While cs1_ni is high, a low cpu_as_ni is treated exactly as if it were high. With ctl_as_ni high and an access open, the cycle is a burst continuation, and it writes if the write inputs request a write.
- R3: When both strobes are low, only cpu_as_ni counts. An access opened by cpu_as_ni is a read, whatever the write inputs and write data are on that edge.
- R4: A write after a cpu_as_ni access takes place on the following edge, with both strobes high. That edge stores dq_i to the held address, using the write inputs sampled on that edge.
- R5: cpu_as_ni high with ctl_as_ni low and a write requested stores dq_i in that same edge, at addr_i.
- R6: A write is requested when wr_all_ni is low, or when byte_en_ni is low and some byte_sel_ni bit is low. With wr_all_ni low, all four lanes are written. Otherwise, lane i (data bits 8i+7..8i) is written only when byte_sel_ni[i] is low. Unwritten lanes keep their contents.
- R7: For an address captured at edge k, its word is on dq_o after edge k+1. dq_oe_o is high then only while out_en_ni is low, and out_en_ni acts without a clock.
- R8: An access that opens from the deselected state leaves dq_oe_o low for the cycle after the opening edge.
- R9: After any write edge, dq_oe_o is low, whatever the level of out_en_ni.
- R10: After a deselect edge, dq_oe_o is low.
- R11: In a continuation cycle, burst_adv_ni low steps the low two address bits by one modulo 4 and keeps the upper bits. burst_adv_ni high holds the address. Both cases apply to reads and writes.
- R12: sleep_i passes through two flops. Once it is seen, dq_oe_o is low, no write happens, the access is closed, and the memory keeps its contents. Leaving sleep also takes two edges.
- R13: After reset, dq_oe_o is low and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| cpu_as_ni | input | 1 | Processor address strobe, active low |
| ctl_as_ni | input | 1 | Controller address strobe, active low |
| cs1_ni | input | 1 | Chip select 1, active low |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_ni | input | 1 | Chip select 3, active low |
| wr_all_ni | input | 1 | Global write, active low |
| byte_en_ni | input | 1 | Byte write enable, active low |
| byte_sel_ni | input | LANES | Per-lane byte select, active low |
| burst_adv_ni | input | 1 | Burst advance, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is the write that follows a processor-strobe access. On that edge, the read pipeline holds a valid word that would normally be driven, and only the write suppression keeps the bus quiet. The bench reaches it by opening with the processor strobe while it drives the global write and junk data, and also the controller strobe. It then holds out_en_ni low through the second edge, so a missing suppression shows at once. The same first edge is read back later to prove the junk was not stored. Sleep is checked one edge at a time, so the two-flop delay on entry and exit is pinned, and a write issued during sleep is shown to leave the old word in place.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START_RD,
    CYC_START_WR,
    CYC_CONT_RD,
    CYC_CONT_WR,
    CYC_SLEEP
  } cyc_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_burst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cpu_as_ni,
  input  logic             ctl_as_ni,
  input  logic             cs1_ni,
  input  logic             cs2_i,
  input  logic             cs3_ni,
  input  logic             wr_all_ni,
  input  logic             byte_en_ni,
  input  logic [LANES-1:0] byte_sel_ni,
  input  logic             burst_adv_ni,
  input  logic             active_i,
  input  logic             sleep_i,
  output cyc_e             cyc_o,
  output logic [LANES-1:0] wr_mask_o,
  output logic             advance_o
);
  logic sel_all, cpu_hit, ctl_hit, wr_req;

  always_comb begin
    sel_all = !cs1_ni && cs2_i && !cs3_ni;
    cpu_hit = !cpu_as_ni && !cs1_ni;   // cpu strobe gated by cs1
    ctl_hit = !ctl_as_ni;
    wr_req  = !wr_all_ni || (!byte_en_ni && (byte_sel_ni != '1));
    cyc_o   = CYC_IDLE;
    if (sleep_i)                    cyc_o = CYC_SLEEP;
    else if (cpu_hit || ctl_hit) begin
      if (!sel_all)                 cyc_o = CYC_DESEL;
      else if (cpu_hit)             cyc_o = CYC_START_RD;
      else if (wr_req)              cyc_o = CYC_START_WR;
      else                          cyc_o = CYC_START_RD;
    end else if (active_i)          cyc_o = wr_req ? CYC_CONT_WR : CYC_CONT_RD;

    if (!wr_all_ni)       wr_mask_o = '1;
    else if (!byte_en_ni) wr_mask_o = ~byte_sel_ni;
    else                  wr_mask_o = '0;

    advance_o = ((cyc_o == CYC_CONT_RD) || (cyc_o == CYC_CONT_WR)) && !burst_adv_ni;
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int AW      = 8,
  parameter int BURST_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          track_i,
  input  logic          advance_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0]      addr_q;
  logic [BURST_W-1:0] low_next;

  always_comb begin
    low_next = addr_q[BURST_W-1:0] + BURST_W'(1);
    if (load_i)         eff_o = addr_i;
    else if (advance_i) eff_o = {addr_q[AW-1:BURST_W], low_next};
    else                eff_o = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (load_i || track_i) addr_q <= eff_o;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[g]) lane_mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          show_d_i,
  input  logic          hide_i,
  input  logic          oe_ni,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic [DW-1:0] dout_q;
  logic          show_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      show_q <= 1'b0;
    end else begin
      if (load_i) dout_q <= rdata_i;
      show_q <= show_d_i;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = show_q && !oe_ni && !hide_i;
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int AW      = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    cpu_as_ni,
  input  logic                    ctl_as_ni,
  input  logic                    cs1_ni,
  input  logic                    cs2_i,
  input  logic                    cs3_ni,
  input  logic                    wr_all_ni,
  input  logic                    byte_en_ni,
  input  logic [LANES-1:0]        byte_sel_ni,
  input  logic                    burst_adv_ni,
  input  logic                    out_en_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int DW = LANES * LANE_W;

  cyc_e             cyc;
  logic [LANES-1:0] wr_mask;
  logic             advance, is_start, is_cont, array_we, is_rd, show_d;
  logic             active_q, acc_rd_q, zz_q1, zz_q2;
  logic [AW-1:0]    eff_addr, addr_q;
  logic [DW-1:0]    rdata;

  sram_cycle_decode #(.LANES(LANES)) u_dec (
    .cpu_as_ni, .ctl_as_ni, .cs1_ni, .cs2_i, .cs3_ni, .wr_all_ni, .byte_en_ni,
    .byte_sel_ni, .burst_adv_ni,
    .active_i (active_q),
    .sleep_i  (zz_q2),
    .cyc_o    (cyc),
    .wr_mask_o(wr_mask),
    .advance_o(advance)
  );

  always_comb begin
    is_start = (cyc == CYC_START_RD) || (cyc == CYC_START_WR);
    is_cont  = (cyc == CYC_CONT_RD)  || (cyc == CYC_CONT_WR);
    array_we = (cyc == CYC_START_WR) || (cyc == CYC_CONT_WR);
    is_rd    = (cyc == CYC_START_RD) || (cyc == CYC_CONT_RD);
    if ((cyc == CYC_SLEEP) || (cyc == CYC_DESEL) || array_we) show_d = 1'b0;
    else if (is_start && !active_q)                          show_d = 1'b0;  // first cycle after deselect
    else                                                      show_d = acc_rd_q && active_q;
  end

  sram_burst_addr #(.AW(AW), .BURST_W(BURST_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i   (is_start),
    .track_i  (is_cont),
    .advance_i(advance),
    .addr_i,
    .eff_o    (eff_addr),
    .addr_o   (addr_q)
  );

  sram_byte_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i,
    .we_i   (array_we),
    .mask_i (wr_mask),
    .waddr_i(eff_addr),
    .wdata_i(dq_i),
    .raddr_i(addr_q),
    .rdata_o(rdata)
  );

  sram_out_stage #(.DW(DW)) u_out (
    .clk_i, .rst_ni,
    .load_i  (acc_rd_q),
    .rdata_i (rdata),
    .show_d_i(show_d),
    .hide_i  (zz_q2),
    .oe_ni   (out_en_ni),
    .dq_o,
    .dq_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      acc_rd_q <= 1'b0;
      zz_q1    <= 1'b0;
      zz_q2    <= 1'b0;
    end else begin
      zz_q1    <= sleep_i;
      zz_q2    <= zz_q1;
      acc_rd_q <= is_rd;
      if (is_start)                                  active_q <= 1'b1;
      else if ((cyc == CYC_DESEL) || (cyc == CYC_SLEEP)) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk #(
  parameter int AW      = 8,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_as_ni,
  input logic             ctl_as_ni,
  input logic             cs1_ni,
  input logic             cs2_i,
  input logic             cs3_ni,
  input logic             wr_all_ni,
  input logic             burst_adv_ni,
  input logic             dq_oe_o,
  input logic             array_we,
  input logic [LANES-1:0] wr_mask,
  input logic             active_q,
  input logic             sleep_q,
  input logic [AW-1:0]    addr_q
);
  logic sel_all, cpu_hit, any_hit;
  assign sel_all = !cs1_ni && cs2_i && !cs3_ni;
  assign cpu_hit = !cpu_as_ni && !cs1_ni;
  assign any_hit = cpu_hit || !ctl_as_ni;

  p_desel_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_hit && !sel_all && !sleep_q) |=> !dq_oe_o);

  p_first_cycle_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_hit && sel_all && !active_q && !sleep_q) |=> !dq_oe_o);

  p_write_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_we |=> !dq_oe_o);

  p_cpu_reads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_hit && !sleep_q) |-> !array_we);

  p_ctl_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_as_ni && cpu_as_ni && sel_all && !wr_all_ni && !sleep_q) |-> (array_we && (&wr_mask)));

  p_cpu_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_as_ni && cs1_ni && ctl_as_ni && burst_adv_ni) |=> $stable(addr_q));

  p_burst_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cpu_as_ni && ctl_as_ni && !burst_adv_ni && !sleep_q) |=>
    (addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + BURST_W'(1))));

  p_sleep_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_q |-> (!array_we && !dq_oe_o));
endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk #(.AW(AW), .LANES(LANES), .BURST_W(BURST_W)) u_chk (
  .clk_i, .rst_ni, .cpu_as_ni, .ctl_as_ni, .cs1_ni, .cs2_i, .cs3_ni, .wr_all_ni,
  .burst_adv_ni, .dq_oe_o,
  .array_we(array_we),
  .wr_mask (wr_mask),
  .active_q(active_q),
  .sleep_q (zz_q2),
  .addr_q  (addr_q)
);

// File: tb/tb_sram_burst_ctrl.sv
module tb_sram_burst_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        cpu_as_n, ctl_as_n, cs1_n, cs2, cs3_n, wr_all_n, byte_en_n, adv_n, oe_n, zz;
  logic [3:0]  bsel_n;
  logic [31:0] dq_in, dq_out;
  logic        dq_oe;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sram_burst_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cpu_as_ni(cpu_as_n), .ctl_as_ni(ctl_as_n),
    .cs1_ni(cs1_n), .cs2_i(cs2), .cs3_ni(cs3_n), .wr_all_ni(wr_all_n), .byte_en_ni(byte_en_n),
    .byte_sel_ni(bsel_n), .burst_adv_ni(adv_n), .out_en_ni(oe_n), .sleep_i(zz),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    cpu_as_n = 1; ctl_as_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
    wr_all_n = 1; byte_en_n = 1; bsel_n = 4'hF; adv_n = 1; oe_n = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic deselect();
    quiet(); ctl_as_n = 0; cs1_n = 1; tick(); quiet();
  endtask

  task automatic ctl_write(input logic [7:0] a, input logic [31:0] d);
    quiet(); ctl_as_n = 0; addr = a; wr_all_n = 0; dq_in = d; tick(); quiet();
  endtask

  // opens from deselect, checks R10/R8 tri-state, then data per R7
  task automatic read_word(input logic [7:0] a, input logic [31:0] exp, input string tag);
    deselect();
    chk("R10 deselect off", {31'b0, dq_oe}, 32'd0);
    ctl_as_n = 0; addr = a; tick(); quiet();
    chk("R8 first cycle off", {31'b0, dq_oe}, 32'd0);
    tick();
    chk(tag, dq_out, exp);
    chk("R7 drive on", {31'b0, dq_oe}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R13 reset off", {31'b0, dq_oe}, 32'd0);
  endtask

  task automatic t_ctl_write();
    deselect();
    ctl_write(8'h10, 32'h1122_3344);
    read_word(8'h10, 32'h1122_3344, "R5 R1 R7 ctl write data");
    oe_n = 1; #1;
    chk("R7 oe high off", {31'b0, dq_oe}, 32'd0);
    oe_n = 0; #1;
    chk("R7 oe low on", {31'b0, dq_oe}, 32'd1);
  endtask

  task automatic t_byte_write();
    quiet(); ctl_as_n = 0; addr = 8'h10; byte_en_n = 0; bsel_n = 4'b1010; dq_in = 32'hAABB_CCDD; tick();
    quiet(); ctl_as_n = 0; addr = 8'h10; byte_en_n = 1; bsel_n = 4'h0; dq_in = 32'h0; tick(); quiet();
    read_word(8'h10, 32'h11BB_33DD, "R6 byte mask");
  endtask

  task automatic t_cpu_write();
    ctl_write(8'h30, 32'h0);
    quiet(); cpu_as_n = 0; ctl_as_n = 0; addr = 8'h30; wr_all_n = 0; dq_in = 32'hDEAD_BEEF; tick();
    quiet(); wr_all_n = 0; dq_in = 32'h5A5A_1234; tick(); quiet();
    chk("R9 write off", {31'b0, dq_oe}, 32'd0);
    read_word(8'h30, 32'h5A5A_1234, "R4 cpu two-edge write");
    ctl_write(8'h31, 32'h0000_7777);
    quiet(); cpu_as_n = 0; ctl_as_n = 0; addr = 8'h31; wr_all_n = 0; dq_in = 32'hFFFF_0000; tick();
    quiet(); tick();
    chk("R3 cpu start is read", dq_out, 32'h0000_7777);
    chk("R3 drive on", {31'b0, dq_oe}, 32'd1);
  endtask

  task automatic t_cs1_gate();
    ctl_write(8'h40, 32'h0000_00C0);
    quiet(); ctl_as_n = 0; addr = 8'h40; tick();
    quiet(); cpu_as_n = 0; cs1_n = 1; addr = 8'h55; wr_all_n = 0; dq_in = 32'h0000_00E1; tick(); quiet();
    read_word(8'h40, 32'h0000_00E1, "R2 gated strobe continues");
  endtask

  task automatic t_burst();
    ctl_write(8'h20, 32'hB000_0000);
    wr_all_n = 0; adv_n = 0; dq_in = 32'hB000_0001; tick();
    dq_in = 32'hB000_0002; tick();
    dq_in = 32'hB000_0003; tick();
    dq_in = 32'hB000_0004; tick(); quiet();
    deselect();
    ctl_as_n = 0; addr = 8'h22; tick(); quiet();
    adv_n = 0; tick(); chk("R11 burst w2", dq_out, 32'hB000_0002);
    tick();            chk("R11 burst w3", dq_out, 32'hB000_0003);
    adv_n = 1; tick(); chk("R11 wrap", dq_out, 32'hB000_0004);
    tick();            chk("R11 suspend", dq_out, 32'hB000_0004);
  endtask

  task automatic t_sleep();
    deselect();
    ctl_as_n = 0; addr = 8'h10; tick(); quiet(); tick();
    zz = 1; tick();
    chk("R12 entry delay", {31'b0, dq_oe}, 32'd1);
    tick();
    chk("R12 asleep off", {31'b0, dq_oe}, 32'd0);
    ctl_write(8'h10, 32'h0BAD_0BAD);
    zz = 0; tick(); tick();
    read_word(8'h10, 32'h11BB_33DD, "R12 contents kept");
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    quiet(); addr = '0; dq_in = '0; zz = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    tick();
    t_ctl_write();
    t_byte_write();
    t_cpu_write();
    t_cs1_gate();
    t_burst();
    t_sleep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule